// File: doc/BRIEF.md
# Page Write Collector with In-Page Wrap

This block gathers the data phase of a serial memory write command and turns it into a timed internal programming cycle. A serial front end tells it when a write command begins, which start address was given and whether the write enable latch was set at that moment. It then passes every data bit it samples, most significant bit first. The block packs the bits into bytes and places each byte in a 64-entry page buffer at the next offset. Offsets wrap inside the current 64-byte page, so a long command overwrites bytes it loaded earlier instead of spilling into the next page. A per-byte valid mask records which offsets were actually received.

When chip select rises, the front end pulses `csRise`. The write is committed only if the bit count sits exactly on a byte boundary and at least one byte arrived. In that case the block raises `writeBusy` for `WR_CYCLES` system clocks. During the first 64 of those clocks it copies every valid buffered byte into the array through a simple synchronous write port. At the end of the cycle it pulses `enLatchClr` so that the surrounding logic can drop the write enable latch. A committed write whose target the protection logic flags through `protHit` is dropped without a cycle, but the latch-clear pulse is still issued. While the cycle runs, all new command, bit and chip-select strobes are ignored.

Top module: `page_collect`

## Requirements
- R1: After reset, `writeBusy`, `enLatchClr` and `memWe` are all 0.
- R2: Data bits arrive on `bitIn` with `bitTick`, most significant bit first. The k-th complete byte of a command (k from 0) is written to address {startAddr[14:6], (startAddr[5:0] + k) mod 64}. Only offsets that received a byte are written.
- R3: When a command carries more than 64 bytes, or crosses the end of the page, a later byte at the same offset replaces the earlier one. Only the last value at each offset reaches the array.
- R4: `csRise` commits only when the number of data bits since `cmdStart` is a nonzero multiple of 8. Otherwise the command is discarded: no array write, no busy, no latch-clear pulse.
- R5: `cmdStart` is taken only when `enLatchIn` is 1 in the same cycle. Otherwise the bits and the `csRise` that follow cause no write, no busy and no pulse.
- R6: After a committing `csRise` without `protHit`, `writeBusy` is 1 for exactly `WR_CYCLES` cycles, starting in the cycle after `csRise`.
- R7: While `writeBusy` is 1, `cmdStart`, `bitTick` and `csRise` have no effect, and the running cycle completes unchanged.
- R8: `enLatchClr` is a single-cycle pulse. It is 1 in the first cycle after a cycle ends, when `writeBusy` has returned to 0.
- R9: A committing `csRise` with `protHit` = 1 writes nothing and keeps `writeBusy` at 0. It pulses `enLatchClr` in the next cycle.
- R10: `memWe` is 1 only while `writeBusy` is 1. All writes of one cycle stay in the committed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Pulse: a write command begins, start address valid |
| startAddr | input | 15 | Start byte address of the command |
| enLatchIn | input | 1 | Write enable latch state at command start |
| bitTick | input | 1 | Pulse: one data bit sampled |
| bitIn | input | 1 | Data bit value, most significant bit first |
| csRise | input | 1 | Pulse: chip select went high |
| protHit | input | 1 | Target is in a protected region (valid with csRise) |
| writeBusy | output | 1 | Internal write cycle in progress |
| enLatchClr | output | 1 | Pulse: clear the write enable latch |
| memWe | output | 1 | Array write strobe |
| memAddr | output | 15 | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
On every cycle the assertions check four things: the busy window lasts exactly `WR_CYCLES` clocks and opens only after a `csRise`; the latch-clear pulse is single and coincides with the end of busy; array writes happen only while busy; and the page part of the write address stays fixed for a whole cycle. Only the bench's scenarios can show the rest. That covers the placement of bytes after offset wrap, the overwrite of earlier bytes, the valid mask leaving unreceived offsets untouched, the discard of commands that end off a byte boundary or without the latch, and the silent drop of protected writes. The bench shows these by comparing the modelled array against the written one.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pgwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // capture start address, clear mask and bit count
    logic shiftBit;   // shift one data bit in
    logic copyEn;     // copy phase: present buffer entry to array port
  } pgwStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic aligned;    // bit count is on a byte boundary
    logic anyByte;    // at least one full byte received
  } pgwStatus_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int OFFS_W    = 6,
  parameter int WR_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              enLatchIn,
  input  logic              bitTick,
  input  logic              csRise,
  input  logic              protHit,
  input  pgwStatus_t        status,
  output pgwStrobe_t        strobe,
  output logic [OFFS_W-1:0] copyIdx,
  output logic              writeBusy,
  output logic              enLatchClr
);

  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1) > OFFS_W ?
                              $clog2(WR_CYCLES + 1) : OFFS_W + 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] COPY_LIM  = CNT_W'(PAGE_BYTES);

  pgwState_t        state, stateNext;
  logic [CNT_W-1:0] cycCnt;
  logic             commitOk;
  logic             clrNext;

  assign commitOk = status.aligned && status.anyByte;

  always_comb begin
    stateNext = state;
    clrNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart && enLatchIn) stateNext = ST_FILL;
      end
      ST_FILL: begin
        if (csRise) begin
          if (commitOk && !protHit) begin
            stateNext = ST_PROG;
          end else begin
            stateNext = ST_IDLE;
            clrNext   = commitOk && protHit;
          end
        end
      end
      ST_PROG: begin
        if (cycCnt == LAST_CNT) begin
          stateNext = ST_IDLE;
          clrNext   = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cycCnt     <= '0;
      enLatchClr <= 1'b0;
    end else begin
      state      <= stateNext;
      enLatchClr <= clrNext;
      if (state == ST_PROG) cycCnt <= cycCnt + 1'b1;
      else                  cycCnt <= '0;
    end
  end

  always_comb begin
    strobe.loadStart = (state == ST_IDLE) && cmdStart && enLatchIn;
    strobe.shiftBit  = (state == ST_FILL) && bitTick && !csRise;
    strobe.copyEn    = (state == ST_PROG) && (cycCnt < COPY_LIM);
  end

  assign copyIdx   = cycCnt[OFFS_W-1:0];
  assign writeBusy = (state == ST_PROG);

endmodule

// File: rtl/pgw_dp.sv
module pgw_dp
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFFS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              bitIn,
  input  logic [OFFS_W-1:0] copyIdx,
  output pgwStatus_t        status,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);

  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PAGE_W     = ADDR_W - OFFS_W;

  logic [PAGE_W-1:0]     pageReg;
  logic [OFFS_W-1:0]     offsReg;
  logic [2:0]            bitCnt;
  logic [6:0]            shiftReg;
  logic                  anyByte;
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic                  byteDone;
  logic [7:0]            newByte;

  assign byteDone = strobe.shiftBit && (bitCnt == 3'd7);
  assign newByte  = {shiftReg, bitIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg   <= '0;
      offsReg   <= '0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      anyByte   <= 1'b0;
      validMask <= '0;
    end else if (strobe.loadStart) begin
      pageReg   <= startAddr[ADDR_W-1:OFFS_W];
      offsReg   <= startAddr[OFFS_W-1:0];
      bitCnt    <= '0;
      shiftReg  <= '0;
      anyByte   <= 1'b0;
      validMask <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= newByte[6:0];
      bitCnt   <= bitCnt + 3'd1;
      if (byteDone) begin
        validMask[offsReg] <= 1'b1;
        offsReg            <= offsReg + 1'b1;
        anyByte            <= 1'b1;
      end
    end
  end

  // buffer entries carry no reset: the mask guards them
  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_buf
    always_ff @(posedge clk) begin
      if (byteDone && (offsReg == OFFS_W'(gi))) pageBuf[gi] <= newByte;
    end
  end

  always_comb begin
    status.aligned = (bitCnt == 3'd0);
    status.anyByte = anyByte;
  end

  assign memWe    = strobe.copyEn && validMask[copyIdx];
  assign memAddr  = {pageReg, copyIdx};
  assign memWdata = pageBuf[copyIdx];

endmodule

// File: rtl/page_collect.sv
module page_collect
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int OFFS_W    = 6,
  parameter int WR_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              enLatchIn,
  input  logic              bitTick,
  input  logic              bitIn,
  input  logic              csRise,
  input  logic              protHit,
  output logic              writeBusy,
  output logic              enLatchClr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata
);

  pgwStrobe_t        strobe;
  pgwStatus_t        status;
  logic [OFFS_W-1:0] copyIdx;

  pgw_ctrl #(.OFFS_W(OFFS_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .enLatchIn(enLatchIn),
    .bitTick(bitTick), .csRise(csRise), .protHit(protHit),
    .status(status), .strobe(strobe), .copyIdx(copyIdx),
    .writeBusy(writeBusy), .enLatchClr(enLatchClr)
  );

  pgw_dp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .bitIn(bitIn), .copyIdx(copyIdx), .status(status),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W    = 15,
  parameter int OFFS_W    = 6,
  parameter int WR_CYCLES = 80
) (
  input logic              clk,
  input logic              rstN,
  input logic              csRise,
  input logic              writeBusy,
  input logic              enLatchClr,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int RUN_W = $clog2(WR_CYCLES + 2);

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)          busyRun <= '0;
    else if (writeBusy) busyRun <= busyRun + 1'b1;
    else                busyRun <= '0;
  end

  // R6: busy window length
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> (busyRun == RUN_W'(WR_CYCLES)));

  // R6: busy opens only after chip select rise
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeBusy) |-> $past(csRise));

  // R8: latch clear coincides with end of busy
  p_clr_at_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> enLatchClr);

  // R8: single-cycle pulse
  p_clr_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    enLatchClr |=> !enLatchClr);

  // R10: writes only while busy
  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> writeBusy);

  // R10: page stays fixed across a cycle
  p_page_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (writeBusy && $past(writeBusy)) |-> $stable(memAddr[ADDR_W-1:OFFS_W]));

endmodule

bind page_collect pgw_checker #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WR_CYCLES(WR_CYCLES)
) u_pgw_checker (
  .clk(clk), .rstN(rstN), .csRise(csRise), .writeBusy(writeBusy),
  .enLatchClr(enLatchClr), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/tb_page_collect.sv
module tb_page_collect;

  localparam int ADDR_W    = 15;
  localparam int OFFS_W    = 6;
  localparam int WR_CYCLES = 80;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdStart, enLatchIn, bitTick, bitIn, csRise, protHit;
  logic [ADDR_W-1:0] startAddr;
  logic              writeBusy, enLatchClr, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  page_collect #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WR_CYCLES(WR_CYCLES)) dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .enLatchIn(enLatchIn), .bitTick(bitTick), .bitIn(bitIn), .csRise(csRise),
    .protHit(protHit), .writeBusy(writeBusy), .enLatchClr(enLatchClr),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // array seen by the design, and reference array
  logic [7:0] arrMem [int];
  logic [7:0] refMem [int];
  logic [7:0] pend   [int];

  always @(posedge clk) if (rstN && memWe) arrMem[int'(memAddr)] = memWdata;

  // behavioural reference model
  int  mState = 0;          // 0 idle, 1 filling, 2 busy
  int  mPage, mOff, mBits, mBytes, mLeft;
  int  mShift;
  bit  expBusy = 0, expClr = 0;

  always @(posedge clk) begin
    expClr = 0;
    if (!rstN) begin
      mState = 0; mLeft = 0;
    end else if (mState == 0) begin
      if (cmdStart && enLatchIn) begin
        mState = 1; mPage = int'(startAddr) / 64; mOff = int'(startAddr) % 64;
        mBits = 0; mBytes = 0; mShift = 0; pend.delete();
      end
    end else if (mState == 1) begin
      if (csRise) begin
        if (mBits == 0 && mBytes > 0) begin
          if (protHit) begin
            expClr = 1; mState = 0;
          end else begin
            foreach (pend[k]) refMem[mPage * 64 + k] = pend[k];
            mState = 2; mLeft = WR_CYCLES;
          end
        end else mState = 0;
      end else if (bitTick) begin
        mShift = ((mShift << 1) | int'(bitIn)) & 255;
        mBits++;
        if (mBits == 8) begin
          pend[mOff] = 8'(mShift);
          mOff = (mOff + 1) % 64; mBytes++; mBits = 0;
        end
      end
    end else begin
      mLeft--;
      if (mLeft == 0) begin expClr = 1; mState = 0; end
    end
    expBusy = (mState == 2);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison (R6, R7, R8, R9 cover busy and pulse timing)
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk(writeBusy == expBusy, "R6", "writeBusy", int'(writeBusy), int'(expBusy));
      chk(enLatchClr == expClr, "R8", "enLatchClr", int'(enLatchClr), int'(expClr));
    end
  end

  task automatic idleIns();
    cmdStart = 0; enLatchIn = 0; bitTick = 0; bitIn = 0; csRise = 0; protHit = 0;
    startAddr = '0;
  endtask

  task automatic startCmd(input int addr, input bit wel);
    @(negedge clk);
    cmdStart = 1; enLatchIn = wel; startAddr = ADDR_W'(addr);
    @(negedge clk);
    cmdStart = 0; enLatchIn = 0;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      bitTick = 1; bitIn = b[i];
      @(negedge clk);
    end
    bitTick = 0; bitIn = 0;
  endtask

  task automatic csUp(input bit prot);
    csRise = 1; protHit = prot;
    @(negedge clk);
    csRise = 0; protHit = 0;
  endtask

  task automatic settle();
    repeat (WR_CYCLES + 6) @(negedge clk);
  endtask

  task automatic cmpArrays(input string req);
    foreach (refMem[a])
      chk(arrMem.exists(a) && arrMem[a] == refMem[a], req, "array byte",
          arrMem.exists(a) ? int'(arrMem[a]) : -1, int'(refMem[a]));
    foreach (arrMem[a])
      chk(refMem.exists(a), req, "unexpected write addr", a, -1);
  endtask

  initial begin
    idleIns();
    rstN = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(writeBusy == 0, "R1", "writeBusy", int'(writeBusy), 0);
    chk(enLatchClr == 0, "R1", "enLatchClr", int'(enLatchClr), 0);
    chk(memWe == 0, "R1", "memWe", int'(memWe), 0);
    rstN = 1;
    @(negedge clk);

    // R2: single byte
    startCmd(16'h0123, 1);
    sendBits(8'hA5, 8);
    csUp(0);
    settle();
    cmpArrays("R2");

    // R2 R3: page crossing wraps to offset 0
    startCmd(16'h0A3C, 1);
    for (int i = 0; i < 10; i++) sendBits(8'(8'h10 + i), 8);
    csUp(0);
    settle();
    cmpArrays("R3");
    chk(!arrMem.exists(16'h0A40), "R3", "next page untouched", 16'h0A40, -1);

    // R3: 70 bytes overwrite earlier ones
    startCmd(16'h1205, 1);
    for (int i = 0; i < 70; i++) sendBits(8'(i * 7 + 3), 8);
    csUp(0);
    settle();
    cmpArrays("R3");

    // R4: chip select rise mid-byte discards
    startCmd(16'h2000, 1);
    for (int i = 0; i < 4; i++) sendBits(8'hEE, 8);
    sendBits(8'hEE, 3);
    csUp(0);
    settle();
    cmpArrays("R4");

    // R4: no byte at all
    startCmd(16'h2100, 1);
    csUp(0);
    settle();
    chk(writeBusy == 0, "R4", "busy after empty", int'(writeBusy), 0);

    // R5: latch not set
    startCmd(16'h3000, 0);
    sendBits(8'h55, 8);
    csUp(0);
    settle();
    cmpArrays("R5");

    // R9: protected target dropped
    startCmd(16'h4000, 1);
    sendBits(8'h77, 8);
    csUp(1);
    settle();
    cmpArrays("R9");

    // R7: strobes during busy ignored
    startCmd(16'h5010, 1);
    sendBits(8'h3C, 8);
    sendBits(8'hC3, 8);
    csUp(0);
    repeat (5) @(negedge clk);
    startCmd(16'h6000, 1);
    sendBits(8'h99, 8);
    csUp(0);
    settle();
    cmpArrays("R7");
    chk(!arrMem.exists(16'h6000), "R7", "write during busy", 16'h6000, -1);

    // R2: fresh command after busy, MSB-first packing
    startCmd(16'h7FFF, 1);
    sendBits(8'h81, 8);
    csUp(0);
    settle();
    cmpArrays("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule